// File: doc/BRIEF.md
# Timed-Unlock Vector Base Select

This block holds the one-bit choice of where the interrupt vector table begins: at address zero, or at the start of a boot region whose address is supplied from outside as a static configuration value. It also turns an interrupt number into the address of its table entry. Each entry is two address units wide, so the address is the base plus twice the number.

The choice is guarded against accidental change. A register write must first set a change-enable bit. That write opens a short window, four cycles by default. Only a write of the select value inside that window is accepted, and it closes the window at once. While the window is open, an output forces interrupts off, so no vector is fetched from a table that is about to move.

Top module: `vbs_vector_base_sel`

## Requirements
- R1: After synchronous reset, the select is 0 (table at zero), the window is closed, `irq_block` is 0 and `vec_base` is 0.
- R2: `vec_base` is 0 when the select is 0, and equals `boot_base` when the select is 1.
- R3: `vec_addr` equals `vec_base + 2*vec_num`, modulo 2^ADDR_W. It follows `vec_num` and `boot_base` combinationally.
- R4: A write with `wr_en`=1 and `wr_unlock`=1 opens the window from the next cycle, and `unlock_open` reads 1.
- R5: With no accepted select write, the window stays open for exactly WINDOW cycles after the unlock write and then closes by itself.
- R6: A write with `wr_en`=1 and `wr_unlock`=0 while the window is open loads `wr_sel` into the select on the next cycle and closes the window in that same cycle.
- R7: A write with `wr_unlock`=0 while the window is closed is ignored, and the select keeps its value.
- R8: A write with `wr_unlock`=1 never changes the select, even when `wr_sel` differs from it.
- R9: `irq_block` is 1 in every cycle the window is open and returns to 0 in the cycle the window closes.
- R10: An unlock write while the window is already open restarts the full WINDOW-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_unlock | input | 1 | Written value of the change-enable bit |
| wr_sel | input | 1 | Written value of the select bit |
| boot_base | input | ADDR_W | Boot region start address (static configuration) |
| vec_num | input | VEC_W | Interrupt number to translate |
| sel_boot | output | 1 | Current select: 1 = boot region, 0 = address zero |
| unlock_open | output | 1 | Change-enable window is open |
| irq_block | output | 1 | Forces interrupts off while the window is open |
| vec_base | output | ADDR_W | Selected table base |
| vec_addr | output | ADDR_W | Table entry address for `vec_num` |

## Verification
The bench builds the block with ADDR_W=16, VEC_W=4 and WINDOW=4. These values keep every window position within a few cycles, so select writes land in the first, a middle and the last open cycle, and one lands in the first cycle after the window closes. A boot base of 0xFFF8 with interrupt number 7 makes the entry address wrap past the top of the 16-bit space. A second unlock write issued in the middle of a window shows that the restart gives the full four cycles again.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    // Base selection encoding held by the select register.
    typedef enum logic {
        BASE_ZERO = 1'b0,
        BASE_BOOT = 1'b1
    } vbs_base_e;

    // One register write as seen at the block's edge.
    typedef struct packed {
        logic en;
        logic unlock;
        logic sel;
    } vbs_wr_t;

    // Decoded intent of a write for the current cycle.
    typedef struct packed {
        logic arm;     // open or restart the change window
        logic take;    // accept the written select value
    } vbs_cmd_t;

    function automatic vbs_cmd_t decode_write(vbs_wr_t w, logic window_open);
        vbs_cmd_t c;
        c.arm  = w.en && w.unlock;
        c.take = w.en && !w.unlock && window_open;
        return c;
    endfunction

endpackage

// File: rtl/vbs_unlock_timer.sv
module vbs_unlock_timer #(
    parameter int unsigned WINDOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic take,
    output logic open_o
);
    localparam int unsigned CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LOAD = CW'(WINDOW);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (arm) begin
            left_q <= LOAD;
        end else if (take) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign open_o = (left_q != '0);
endmodule

// File: rtl/vbs_select_reg.sv
module vbs_select_reg
    import vbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  logic      wsel,
    output vbs_base_e sel_o
);
    vbs_base_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= BASE_ZERO;
        end else if (take) begin
            sel_q <= wsel ? BASE_BOOT : BASE_ZERO;
        end
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/vbs_vector_gen.sv
module vbs_vector_gen
    import vbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned VEC_W  = 5
) (
    input  vbs_base_e          sel,
    input  logic [ADDR_W-1:0]  boot_base,
    input  logic [VEC_W-1:0]   vec_num,
    output logic [ADDR_W-1:0]  base_o,
    output logic [ADDR_W-1:0]  addr_o
);
    localparam int unsigned OFS_W = VEC_W + 1;

    logic [OFS_W-1:0]  ofs_raw;
    logic [ADDR_W-1:0] ofs;

    assign ofs_raw = {vec_num, 1'b0};
    assign ofs     = ADDR_W'(ofs_raw);

    always_comb begin
        base_o = (sel == BASE_BOOT) ? boot_base : '0;
        addr_o = base_o + ofs;
    end
endmodule

// File: rtl/vbs_vector_base_sel.sv
module vbs_vector_base_sel
    import vbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned VEC_W  = 5,
    parameter int unsigned WINDOW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_unlock,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] boot_base,
    input  logic [VEC_W-1:0]  vec_num,
    output logic              sel_boot,
    output logic              unlock_open,
    output logic              irq_block,
    output logic [ADDR_W-1:0] vec_base,
    output logic [ADDR_W-1:0] vec_addr
);
    vbs_wr_t   wr;
    vbs_cmd_t  cmd;
    vbs_base_e sel;
    logic      win_open;

    assign wr  = '{en: wr_en, unlock: wr_unlock, sel: wr_sel};
    assign cmd = decode_write(wr, win_open);

    vbs_unlock_timer #(.WINDOW(WINDOW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (cmd.arm),
        .take   (cmd.take),
        .open_o (win_open)
    );

    vbs_select_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .take  (cmd.take),
        .wsel  (wr.sel),
        .sel_o (sel)
    );

    vbs_vector_gen #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_vec (
        .sel       (sel),
        .boot_base (boot_base),
        .vec_num   (vec_num),
        .base_o    (vec_base),
        .addr_o    (vec_addr)
    );

    assign sel_boot    = (sel == BASE_BOOT);
    assign unlock_open = win_open;
    assign irq_block   = win_open;
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
    parameter int unsigned WINDOW = 4
) (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic wr_unlock,
    input logic wr_sel,
    input logic sel_boot,
    input logic unlock_open
);
    localparam int unsigned LW = $clog2(WINDOW + 2) + 1;

    // Length of the current open stretch, counted independently of the design.
    logic [LW-1:0] open_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            open_len <= '0;
        end else if (wr_en && wr_unlock) begin
            open_len <= LW'(1);
        end else if (unlock_open && open_len != '1) begin
            open_len <= open_len + 1'b1;
        end else if (!unlock_open) begin
            open_len <= '0;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!sel_boot && !unlock_open));

    assert_unlock_opens_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_unlock) |=> unlock_open);

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (rst)
        unlock_open |-> (open_len <= LW'(WINDOW)));

    assert_take_closes_R6: assert property (@(posedge clk) disable iff (rst)
        (unlock_open && wr_en && !wr_unlock) |=> (!unlock_open && sel_boot == $past(wr_sel)));

    assert_closed_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        !(unlock_open && wr_en && !wr_unlock) |=> $stable(sel_boot));

    assert_unlock_keeps_sel_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_unlock) |=> $stable(sel_boot));

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (unlock_open && wr_en && wr_unlock) |=> (unlock_open && open_len == LW'(1)));
endmodule

bind vbs_vector_base_sel vbs_checker #(.WINDOW(WINDOW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_unlock   (wr_unlock),
    .wr_sel      (wr_sel),
    .sel_boot    (sel_boot),
    .unlock_open (unlock_open)
);

// File: tb/sim_vbs_vector_base_sel.sv
module sim_vbs_vector_base_sel;
    localparam int unsigned AW  = 16;
    localparam int unsigned VW  = 4;
    localparam int unsigned WIN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, wr_unlock = 1'b0, wr_sel = 1'b0;
    logic [AW-1:0] boot_base = 16'hF000;
    logic [VW-1:0] vec_num = '0;
    logic          sel_boot, unlock_open, irq_block;
    logic [AW-1:0] vec_base, vec_addr;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic          sel;
        logic          open;
        logic [AW-1:0] base;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;
    exp_t sb[$];

    // Reference state kept by the driver from the requirements.
    logic m_sel  = 1'b0;
    logic m_open = 1'b0;
    int   m_left = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    vbs_vector_base_sel #(.ADDR_W(AW), .VEC_W(VW), .WINDOW(WIN)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_unlock(wr_unlock), .wr_sel(wr_sel),
        .boot_base(boot_base), .vec_num(vec_num), .sel_boot(sel_boot),
        .unlock_open(unlock_open), .irq_block(irq_block),
        .vec_base(vec_base), .vec_addr(vec_addr)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outcome.
    task automatic cyc(input logic en, input logic unl, input logic s,
                       input logic [VW-1:0] n, input string tag);
        exp_t e;
        logic [AW-1:0] b;
        @(negedge clk);
        wr_en = en; wr_unlock = unl; wr_sel = s; vec_num = n;
        @(posedge clk);
        if (en && unl) begin
            m_open = 1'b1; m_left = WIN;                 // R4, R8, R10
        end else if (en && m_open) begin
            m_sel = s; m_open = 1'b0; m_left = 0;        // R6
        end else if (m_open) begin
            m_left--;                                     // R5
            if (m_left == 0) m_open = 1'b0;
        end
        b = m_sel ? boot_base : '0;                       // R2
        e.sel = m_sel; e.open = m_open; e.base = b;
        e.addr = b + AW'({n, 1'b0});                      // R3
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each edge.
    always @(posedge clk) begin
        #1;
        while (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            check(sel_boot == e.sel, e.tag, "sel_boot", AW'(sel_boot), AW'(e.sel));
            check(unlock_open == e.open, e.tag, "unlock_open", AW'(unlock_open), AW'(e.open));
            check(irq_block == e.open, e.tag, "irq_block R9", AW'(irq_block), AW'(e.open));
            check(vec_base == e.base, e.tag, "vec_base", vec_base, e.base);
            check(vec_addr == e.addr, e.tag, "vec_addr", vec_addr, e.addr);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #400000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        check(!sel_boot && !unlock_open && !irq_block && vec_base == '0, "R1", "reset",
              {sel_boot, unlock_open, irq_block, vec_base[12:0]}, '0);

        // R2, R3: base zero, sweep of interrupt numbers
        for (int i = 0; i < 16; i += 5) cyc(0, 0, 0, VW'(i), "R2_R3");
        // R7: select write while closed
        cyc(1, 0, 1, 3, "R7");
        cyc(0, 0, 0, 3, "R7");
        // R4, R8, R9: unlock write with differing select value
        cyc(1, 1, 1, 2, "R4_R8");
        cyc(0, 0, 0, 2, "R9");
        // R6: accepted select write in the second open cycle
        cyc(1, 0, 1, 2, "R6");
        for (int i = 0; i < 16; i += 3) cyc(0, 0, 0, VW'(i), "R2_R3");
        // R5, R9: window runs out, then a late write is ignored (R7)
        cyc(1, 1, 0, 1, "R4");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, "R5");
        cyc(1, 0, 0, 1, "R7");
        // R10: restart mid-window, then count the full window again
        cyc(1, 1, 0, 0, "R4");
        cyc(0, 0, 0, 0, "R10");
        cyc(1, 1, 0, 0, "R10");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R10");
        // R6: select write in the last open cycle
        cyc(1, 0, 0, 0, "R6");
        cyc(0, 0, 0, 5, "R6");
        // R3: wrap of the entry address past the top of the space
        cyc(1, 1, 0, 7, "R4");
        cyc(1, 0, 1, 7, "R6");
        @(negedge clk); boot_base = 16'hFFF8;
        cyc(0, 0, 0, 7, "R3");
        cyc(0, 0, 0, 15, "R3");
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule